// File: doc/BRIEF.md
# Guarded One-Time-Programmable Word Store Controller

This block fronts a 128-word by 32-bit one-time-programmable array, which is modelled here as registers. A host never touches the array directly. It loads a word index into an index register and a value into a value register. It then starts an operation by writing an opcode to a command register. A fetch copies the selected word into the value register in one clock. A burn runs a fixed multi-cycle pulse and then merges the value into the stored word. The merge can only pull bits from 1 to 0.

Burns are guarded in three ways. First, a guard register must hold an arming key before any burn is accepted. Writing zero to the guard register seals the array for good. Second, an input pin must report that the high programming supply is present. Third, the lower half of the array holds factory data and always refuses burns from this interface. Once a word in a small window of secret key words has been burned, it is never returned. A fetch of such a word yields a fixed mask value instead. A status register reports busy, done, armed, sealed and error.

Top module: `otp_guard_ctrl`

## Requirements
- R1: After reset every word fetches as 0xFFFFFFFF. The status register (offset 4) reads 0, with bit0 busy, bit1 done, bit2 armed, bit3 sealed and bit4 error.
- R2: Writing 1 to the command register (offset 2) fetches the word selected by the index register (offset 0) into the value register (offset 1) at the same clock edge, and sets done.
- R3: An accepted burn leaves the stored word equal to the old word ANDed with the value register, so bits only ever go from 1 to 0.
- R4: Writing 0x50FA50FA to the guard register (offset 3) sets armed. Writing 0 while not sealed sets sealed and clears armed. Once sealed, no guard write, including the arming key, changes the state.
- R5: A burn (command 2) while not armed is refused: error is set, busy never rises and the word is unchanged.
- R6: A burn while `prog_supply_ok` is low is refused in the same way.
- R7: A burn to any index below 64 (factory half) is refused in the same way, whatever the guard state.
- R8: An accepted burn holds busy for exactly PULSE (16) clocks. All register writes during busy are ignored.
- R9: Done is set when a fetch or a burn completes. Error is set by a refused burn. An accepted command clears error. Done and error are never both set.
- R10: Words 64 to 67 are secret key words. A fetch of one of them returns 0x00000000 once it differs from all ones, and returns the stored value while it still reads all ones.
- R11: Command values other than 1 and 2 are ignored and leave status unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| prog_supply_ok | input | 1 | High when the programming supply is at its high level |

## Verification
On every cycle the assertions check the following. The seal is sticky and only the key can arm. A burn pulse starts only with armed state, supply present and a customer index. Operands stay stable while busy. Bits never rise in a burned word. Done and error never coincide. A key-word fetch after burning yields the mask. The exact pulse length, the refusal of writes during busy, the ignored command values, and the AND result across a sweep of every customer word with two patterns each can only be shown by the bench's scenarios.

// File: rtl/otp_guard_pkg.sv
package otp_guard_pkg;
    localparam int DW = 32;
    typedef enum logic [1:0] {
        GUARD_OPEN   = 2'd0,
        GUARD_ARMED  = 2'd1,
        GUARD_SEALED = 2'd2
    } guard_state_e;
    localparam logic [2:0] RA_INDEX  = 3'd0;
    localparam logic [2:0] RA_VALUE  = 3'd1;
    localparam logic [2:0] RA_CMD    = 3'd2;
    localparam logic [2:0] RA_GUARD  = 3'd3;
    localparam logic [2:0] RA_STATUS = 3'd4;
    localparam logic [DW-1:0] CMD_FETCH = 32'd1;
    localparam logic [DW-1:0] CMD_BURN  = 32'd2;
    localparam logic [DW-1:0] ARM_KEY   = 32'h50FA50FA;
endpackage

// File: rtl/otp_guard_prot.sv
module otp_guard_prot
    import otp_guard_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output logic          armed,
    output logic          sealed
);
    typedef struct packed {
        guard_state_e st;
    } guard_t;

    guard_t g_d, g_q;

    always_comb begin
        g_d = g_q;
        if (wr_en && g_q.st != GUARD_SEALED) begin
            if (wr_data == ARM_KEY)
                g_d.st = GUARD_ARMED;
            else if (wr_data == '0)
                g_d.st = GUARD_SEALED;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) g_q <= '{st: GUARD_OPEN};
        else        g_q <= g_d;
    end

    assign armed  = (g_q.st == GUARD_ARMED);
    assign sealed = (g_q.st == GUARD_SEALED);

    AST_SEAL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        sealed |=> sealed && !armed); // R4
    AST_ARM_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(armed) |-> $past(wr_en) && $past(wr_data) == ARM_KEY); // R4
endmodule

// File: rtl/otp_guard_array.sv
module otp_guard_array
    import otp_guard_pkg::*;
#(
    parameter int WORDS = 128,
    localparam int AW = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pgm_en,
    input  logic [AW-1:0] pgm_addr,
    input  logic [DW-1:0] pgm_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_word
);
    logic [WORDS-1:0][DW-1:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        if (pgm_en)
            mem_d[pgm_addr] = mem_q[pgm_addr] & pgm_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem_q <= '1;
        else        mem_q <= mem_d;
    end

    assign rd_word = mem_q[rd_addr];

    AST_BITS_ONLY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        pgm_en |=> (mem_q[$past(pgm_addr)] & ~$past(mem_q[pgm_addr])) == '0); // R3
endmodule

// File: rtl/otp_guard_pulse.sv
module otp_guard_pulse #(
    parameter int PULSE = 16,
    localparam int CW = (PULSE > 1) ? $clog2(PULSE) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic fire
);
    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
    } pulse_t;

    pulse_t p_d, p_q;

    always_comb begin
        p_d = p_q;
        if (p_q.busy) begin
            if (p_q.cnt == '0) p_d.busy = 1'b0;
            else               p_d.cnt  = p_q.cnt - 1'b1;
        end else if (start) begin
            p_d.busy = 1'b1;
            p_d.cnt  = CW'(PULSE - 1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign busy = p_q.busy;
    assign fire = p_q.busy && (p_q.cnt == '0);

    AST_FIRE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !busy); // R8
    AST_BUSY_UNTIL_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !fire |=> busy); // R8
endmodule

// File: rtl/otp_guard_ctrl.sv
module otp_guard_ctrl
    import otp_guard_pkg::*;
#(
    parameter int WORDS = 128,
    parameter int PULSE = 16,
    parameter int KEY_BASE = 64,
    parameter int KEY_WORDS = 4,
    parameter logic [31:0] MASK_VALUE = 32'h0000_0000,
    localparam int AW = $clog2(WORDS),
    localparam int HALF = WORDS / 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        prog_supply_ok
);
    typedef struct packed {
        logic [AW-1:0] index;
        logic [DW-1:0] value;
        logic          done;
        logic          err;
    } ctrl_t;

    ctrl_t c_d, c_q;

    logic          busy, fire, armed, sealed;
    logic          guard_we, start;
    logic [DW-1:0] rd_word, view_word;
    logic          key_hit, acc, cmd_wr, is_fetch, is_burn, burn_ok;

    otp_guard_prot u_prot (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (guard_we),
        .wr_data (reg_wdata),
        .armed   (armed),
        .sealed  (sealed)
    );

    otp_guard_array #(.WORDS(WORDS)) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .pgm_en   (fire),
        .pgm_addr (c_q.index),
        .pgm_data (c_q.value),
        .rd_addr  (c_q.index),
        .rd_word  (rd_word)
    );

    otp_guard_pulse #(.PULSE(PULSE)) u_pulse (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .busy  (busy),
        .fire  (fire)
    );

    always_comb begin
        acc      = reg_we && !busy;
        cmd_wr   = acc && (reg_addr == RA_CMD);
        is_fetch = cmd_wr && (reg_wdata == CMD_FETCH);
        is_burn  = cmd_wr && (reg_wdata == CMD_BURN);
        burn_ok  = armed && prog_supply_ok && (int'(c_q.index) >= HALF);
        start    = is_burn && burn_ok;
        guard_we = acc && (reg_addr == RA_GUARD);
        key_hit  = (int'(c_q.index) >= KEY_BASE) && (int'(c_q.index) < KEY_BASE + KEY_WORDS);
        view_word = (key_hit && rd_word != '1) ? MASK_VALUE : rd_word;

        c_d = c_q;
        if (acc && reg_addr == RA_INDEX) c_d.index = reg_wdata[AW-1:0];
        if (acc && reg_addr == RA_VALUE) c_d.value = reg_wdata;
        if (is_fetch) begin
            c_d.value = view_word;
            c_d.done  = 1'b1;
            c_d.err   = 1'b0;
        end
        if (is_burn) begin
            c_d.done = 1'b0;
            c_d.err  = !burn_ok;
        end
        if (fire) c_d.done = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    always_comb begin
        unique case (reg_addr)
            RA_INDEX:  reg_rdata = 32'(c_q.index);
            RA_VALUE:  reg_rdata = c_q.value;
            RA_STATUS: reg_rdata = {27'd0, c_q.err, sealed, armed, c_q.done, busy};
            default:   reg_rdata = '0;
        endcase
    end

    AST_START_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> armed); // R5
    AST_START_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(prog_supply_ok)); // R6
    AST_START_CUSTOMER: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> int'(c_q.index) >= HALF); // R7
    AST_BUSY_HOLDS_OPERANDS: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) |-> $stable(c_q.index) && $stable(c_q.value)); // R8
    AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(c_q.done && c_q.err)); // R9
    AST_KEY_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        is_fetch && key_hit && rd_word != '1 |=> c_q.value == MASK_VALUE); // R10
endmodule

// File: tb/otp_guard_ctrl_bench.sv
module otp_guard_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        prog_supply_ok = 1'b1;

    int errors = 0;
    int checks = 0;
    bit ended = 0;
    logic [31:0] mirror [128];

    otp_guard_ctrl u_otp_guard_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .reg_we         (reg_we),
        .reg_addr       (reg_addr),
        .reg_wdata      (reg_wdata),
        .reg_rdata      (reg_rdata),
        .prog_supply_ok (prog_supply_ok)
    );

    always #2.5 clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp_v);
        checks++;
        if (act !== exp_v) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp_v);
        end
    endtask

    task automatic wreg(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rreg(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic fetch(input int idx, output logic [31:0] v);
        wreg(3'd0, 32'(idx));
        wreg(3'd2, 32'd1);
        rreg(3'd1, v);
    endtask

    task automatic burn(input int idx, input logic [31:0] d, output int n);
        logic [31:0] s;
        wreg(3'd0, 32'(idx));
        wreg(3'd1, d);
        wreg(3'd2, 32'd2);
        n = 0;
        rreg(3'd4, s);
        while (s[0] && n < 100) begin
            n++;
            @(negedge clk);
            rreg(3'd4, s);
        end
    endtask

    initial begin
        #750000;
        if (!ended) begin
            ended = 1;
            errors++; checks++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, s, p;
        int n;
        for (int i = 0; i < 128; i++) mirror[i] = 32'hFFFF_FFFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        rreg(3'd4, s); check("R1 status after reset", s, 32'h0);
        for (int i = 0; i < 128; i++) begin
            fetch(i, v); check("R1 blank word", v, 32'hFFFF_FFFF);
        end
        rreg(3'd4, s); check("R2 done after fetch", s, 32'h2);

        burn(100, 32'h0, n);
        rreg(3'd4, s); check("R5 refused unarmed status", s, 32'h10);
        check("R5 no busy when unarmed", 32'(n), 32'd0);
        fetch(100, v); check("R5 word unchanged", v, 32'hFFFF_FFFF);
        burn(100, 32'h0, n);
        wreg(3'd2, 32'd3); rreg(3'd4, s); check("R11 cmd 3 ignored", s, 32'h10);
        wreg(3'd2, 32'd0); rreg(3'd4, s); check("R11 cmd 0 ignored", s, 32'h10);

        wreg(3'd3, 32'h50FA50FA); rreg(3'd4, s); check("R4 armed by key", s, 32'h14);

        prog_supply_ok = 1'b0;
        burn(100, 32'h0, n);
        rreg(3'd4, s); check("R6 refused without supply", s, 32'h14);
        check("R6 no busy", 32'(n), 32'd0);
        prog_supply_ok = 1'b1;
        fetch(100, v); check("R6 word unchanged", v, 32'hFFFF_FFFF);
        check("R9 accepted fetch clears error", v, 32'hFFFF_FFFF);
        rreg(3'd4, s); check("R9 status after fetch", s, 32'h6);

        burn(10, 32'h0, n);  rreg(3'd4, s); check("R7 factory 10 refused", s, 32'h14);
        burn(63, 32'h0, n);  rreg(3'd4, s); check("R7 factory 63 refused", s, 32'h14);
        check("R7 no busy at 63", 32'(n), 32'd0);
        fetch(63, v); check("R7 word 63 unchanged", v, 32'hFFFF_FFFF);

        burn(64, 32'h1234_5678, n);
        check("R8 pulse length", 32'(n), 32'd16);
        rreg(3'd4, s); check("R9 done after burn", s, 32'h6);
        fetch(64, v); check("R10 key word masked", v, 32'h0);
        burn(65, 32'hFFFF_FFFF, n);
        fetch(65, v); check("R10 blank key word visible", v, 32'hFFFF_FFFF);
        fetch(67, v); check("R10 last key word blank", v, 32'hFFFF_FFFF);

        for (int pass = 0; pass < 2; pass++) begin
            for (int a = 68; a < 128; a++) begin
                p = (pass == 0) ? ~(32'h1 << (a % 32)) & ~(32'h8000_0000 >> (a % 7))
                                : {a[7:0], ~a[7:0], 16'hF0F0} | (32'h0101_0101 << (a % 8));
                mirror[a] = mirror[a] & p;
                burn(a, p, n);
                check("R8 pulse in sweep", 32'(n), 32'd16);
                fetch(a, v); check("R3 AND merge", v, mirror[a]);
            end
        end

        wreg(3'd0, 32'd100);
        wreg(3'd1, 32'h00FF_00FF);
        wreg(3'd2, 32'd2);
        wreg(3'd0, 32'd5);
        wreg(3'd1, 32'h0);
        wreg(3'd2, 32'd1);
        wreg(3'd3, 32'h0);
        repeat (20) @(negedge clk);
        rreg(3'd0, v); check("R8 index write ignored in busy", v, 32'd100);
        rreg(3'd4, s); check("R8 guard write ignored in busy", s, 32'h6);
        mirror[100] = mirror[100] & 32'h00FF_00FF;
        fetch(100, v); check("R3 burn with stable operands", v, mirror[100]);
        fetch(5, v); check("R8 factory word untouched", v, 32'hFFFF_FFFF);

        wreg(3'd3, 32'h0); rreg(3'd4, s); check("R4 sealed", s & 32'hC, 32'h8);
        burn(120, 32'h0, n); rreg(3'd4, s); check("R4 burn refused when sealed", s, 32'h18);
        fetch(120, v); check("R4 sealed word unchanged", v, mirror[120]);
        wreg(3'd3, 32'h50FA50FA); rreg(3'd4, s); check("R4 key after seal", s & 32'hC, 32'h8);
        burn(121, 32'h0, n); check("R4 no pulse after reseal attempt", 32'(n), 32'd0);
        fetch(121, v); check("R4 word still intact", v, mirror[121]);
        fetch(64, v); check("R10 mask after seal", v, 32'h0);

        if (!ended) begin
            ended = 1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule